// File: doc/BRIEF.md
# Dual-Thread Core Idle-State Coordinator

This block keeps track of the idle state that each of two hardware threads has asked for, and it derives one power state for the whole core from them. A thread that is running (C0) can issue an entry request. The request carries a kind (halt, monitor-wait or port-style) and a target state. The thread stays in the state it entered until a wake event arrives. Which wake events count depends on how the thread got into that state. When the enhanced-idle enable is set at the moment of entry, the lightest idle state is recorded as its enhanced variant.

The core state is the shallowest of the two thread states and is visible in the same cycle as the thread states. A snoop handshake runs beside the state machines. It is always acknowledged one cycle later, and no thread is woken to serve it. The block does only bookkeeping and wake decisions. Clocks, voltages and caches are left to other logic.

Each thread has its own state machine with five named states. RUN is code 0 (C0), LIGHT is code 1 (C1), LIGHT_ENH is code 2 (C1E), DEEP is code 3 (C3) and DEEPEST is code 4 (C6). It has four kinds of transition:
- **enter**: RUN to another state, on an accepted request.
- **irq-wake**: any other state to RUN, on an interrupt.
- **monitor-wake**: any other state to RUN, on a monitored-address hit, but only if the state was entered by monitor-wait.
- **hold**: every other case.

Top module: `core_idle_coord`

## Requirements
- R1: After reset both thread states and the core state read 0 (C0), and the snoop acknowledge is low.
- R2: A request of kind 0 (halt) taken in C0 moves the thread to C1 (code 1) on the next clock edge, whatever the target field holds. If the enhanced enable is set it moves to C1E (code 2) instead.
- R3: A request of kind 1 (monitor-wait) taken in C0 acts on its target as follows:
  - target 1 or 2 moves the thread to C1 or C1E (as in R2);
  - target 3 moves it to C3;
  - target 4 moves it to C6;
  - targets 0, 5, 6 and 7 are dropped, and the thread stays in C0.
- R4: A request of kind 2 (port-style) taken in C0 acts on its target as follows:
  - target 3 moves the thread to C3;
  - target 4 moves it to C6;
  - any other target is dropped.
- R5: The choice between C1 and C1E is fixed at entry. Changing the enhanced enable while the thread is idle leaves its state unchanged.
- R6: An interrupt to a thread that is not in C0 returns it to C0 on the next edge.
- R7: A monitored-address hit returns a thread to C0 only when its current state was entered by monitor-wait. After a halt or port-style entry the hit is ignored.
- R8: Entry requests that arrive while the thread is not in C0 are dropped. So are requests of the reserved kind 3, in any state.
- R9: The core state equals the numerically smallest (shallowest) of the two thread codes. C6 appears only when both threads are in C6.
- R10: A snoop request sampled on an edge raises the snoop acknowledge for exactly the following cycle, in every power state, and it changes no thread state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_idle_en | input | 1 | Record light idle as enhanced variant |
| req_valid | input | 2 | Entry request strobe, one bit per thread |
| req_kind | input | 4 | Request kind per thread (2 bits each, thread 0 in low bits) |
| req_target | input | 6 | Target state code per thread (3 bits each) |
| irq | input | 2 | Interrupt wake per thread |
| mon_hit | input | 2 | Monitored-address access per thread |
| snoop_req | input | 1 | Snoop request |
| snoop_ack | output | 1 | Snoop acknowledge, one cycle after request |
| thread_state | output | 6 | State code per thread (3 bits each) |
| core_state | output | 3 | Resolved core state code |

## Verification
The clocked properties assume that all inputs are known and stable at each rising edge, and that the reset is held low for at least one edge. The bench changes every input only on the falling clock edge and starts from a held reset, so these assumptions hold. The properties do not limit request kinds or targets, so the stimulus deliberately uses reserved kinds, out-of-range targets, and wake events that arrive together with requests. The properties also assume that the enhanced enable may change at any time, and the bench toggles it while threads are idle.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;
    localparam int STATE_W = 3;
    localparam int KIND_W  = 2;

    typedef enum logic [STATE_W-1:0] {
        PS_RUN       = 3'd0,
        PS_LIGHT     = 3'd1,
        PS_LIGHT_ENH = 3'd2,
        PS_DEEP      = 3'd3,
        PS_DEEPEST   = 3'd4
    } pstate_e;

    typedef enum logic [KIND_W-1:0] {
        RQ_HALT  = 2'd0,
        RQ_MWAIT = 2'd1,
        RQ_PORT  = 2'd2,
        RQ_RSVD  = 2'd3
    } rqkind_e;
endpackage

// File: rtl/idle_thread_fsm.sv
module idle_thread_fsm
    import idle_coord_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enh_en,
    input  logic               req_valid,
    input  logic [KIND_W-1:0]  req_kind,
    input  logic [STATE_W-1:0] req_target,
    input  logic               irq,
    input  logic               mon_hit,
    output logic [STATE_W-1:0] state_o
);
    pstate_e state_q, state_d;
    logic    mw_q, mw_d;
    pstate_e light_state;

    assign light_state = enh_en ? PS_LIGHT_ENH : PS_LIGHT;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            mw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            mw_q    <= mw_d;
        end
    end

    // next-state: enter / irq-wake / monitor-wake / hold
    always_comb begin
        state_d = state_q;
        mw_d    = mw_q;
        unique case (state_q)
            PS_RUN: begin
                mw_d = 1'b0;
                if (req_valid) begin
                    case (req_kind)
                        RQ_HALT: state_d = light_state;
                        RQ_MWAIT: begin
                            case (req_target)
                                3'd1, 3'd2: begin state_d = light_state; mw_d = 1'b1; end
                                3'd3:       begin state_d = PS_DEEP;     mw_d = 1'b1; end
                                3'd4:       begin state_d = PS_DEEPEST;  mw_d = 1'b1; end
                                default:    state_d = PS_RUN;
                            endcase
                        end
                        RQ_PORT: begin
                            case (req_target)
                                3'd3:    state_d = PS_DEEP;
                                3'd4:    state_d = PS_DEEPEST;
                                default: state_d = PS_RUN;
                            endcase
                        end
                        default: state_d = PS_RUN;
                    endcase
                end
            end
            PS_LIGHT, PS_LIGHT_ENH, PS_DEEP, PS_DEEPEST: begin
                if (irq || (mon_hit && mw_q)) begin
                    state_d = PS_RUN;
                    mw_d    = 1'b0;
                end
            end
            default: begin
                state_d = PS_RUN;
                mw_d    = 1'b0;
            end
        endcase
    end

    // outputs
    always_comb begin
        state_o = state_q;
    end

    assert_wake_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_RUN && irq) |=> (state_q == PS_RUN));

    assert_mon_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_RUN && !mw_q && !irq) |=> $stable(state_q));

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN) |-> !mw_q);

    assert_drop_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_RUN && req_valid && !irq && !mon_hit) |=> $stable(state_q));

    assert_mwait_deepest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_RUN && req_valid && req_kind == RQ_MWAIT && req_target == 3'd4)
        |=> (state_q == PS_DEEPEST && mw_q));

    assert_enh_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_LIGHT && !irq && !mon_hit) |=> (state_q == PS_LIGHT));
endmodule

// File: rtl/core_state_resolve.sv
module core_state_resolve
    import idle_coord_pkg::*;
#(
    parameter int NTHR = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NTHR*STATE_W-1:0] thr_state,
    output logic [STATE_W-1:0]      core_state
);
    always_comb begin
        core_state = thr_state[STATE_W-1:0];
        for (int i = 1; i < NTHR; i++) begin
            if (thr_state[i*STATE_W +: STATE_W] < core_state)
                core_state = thr_state[i*STATE_W +: STATE_W];
        end
    end

    for (genvar g = 0; g < NTHR; g++) begin : g_chk
        assert_not_deeper_R9: assert property (@(posedge clk) disable iff (!rst_n)
            core_state <= thr_state[g*STATE_W +: STATE_W]);
    end

    assert_deepest_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == 3'd4) |-> (thr_state == {NTHR{3'd4}}));
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder (
    input  logic clk,
    input  logic rst_n,
    input  logic snoop_req,
    output logic snoop_ack
);
    always_ff @(posedge clk) begin
        if (!rst_n) snoop_ack <= 1'b0;
        else        snoop_ack <= snoop_req;
    end

    assert_ack_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_req |=> snoop_ack);

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_req |=> !snoop_ack);
endmodule

// File: rtl/core_idle_coord.sv
module core_idle_coord
    import idle_coord_pkg::*;
#(
    parameter int NTHR = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enh_idle_en,
    input  logic [NTHR-1:0]         req_valid,
    input  logic [NTHR*KIND_W-1:0]  req_kind,
    input  logic [NTHR*STATE_W-1:0] req_target,
    input  logic [NTHR-1:0]         irq,
    input  logic [NTHR-1:0]         mon_hit,
    input  logic                    snoop_req,
    output logic                    snoop_ack,
    output logic [NTHR*STATE_W-1:0] thread_state,
    output logic [STATE_W-1:0]      core_state
);
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        idle_thread_fsm u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .enh_en     (enh_idle_en),
            .req_valid  (req_valid[t]),
            .req_kind   (req_kind[t*KIND_W +: KIND_W]),
            .req_target (req_target[t*STATE_W +: STATE_W]),
            .irq        (irq[t]),
            .mon_hit    (mon_hit[t]),
            .state_o    (thread_state[t*STATE_W +: STATE_W])
        );
    end

    core_state_resolve #(.NTHR(NTHR)) u_resolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .thr_state  (thread_state),
        .core_state (core_state)
    );

    snoop_responder u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .snoop_req (snoop_req),
        .snoop_ack (snoop_ack)
    );

    assert_snoop_no_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_req && irq == '0 && mon_hit == '0 && core_state != 3'd0) |=> $stable(core_state));
endmodule

// File: tb/core_idle_coord_tb.sv
module core_idle_coord_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enh_idle_en = 1'b0;
    logic [1:0] req_valid = '0;
    logic [3:0] req_kind = '0;
    logic [5:0] req_target = '0;
    logic [1:0] irq = '0;
    logic [1:0] mon_hit = '0;
    logic       snoop_req = 1'b0;
    logic       snoop_ack;
    logic [5:0] thread_state;
    logic [2:0] core_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    core_idle_coord u_dut (
        .clk(clk), .rst_n(rst_n), .enh_idle_en(enh_idle_en),
        .req_valid(req_valid), .req_kind(req_kind), .req_target(req_target),
        .irq(irq), .mon_hit(mon_hit), .snoop_req(snoop_req),
        .snoop_ack(snoop_ack), .thread_state(thread_state), .core_state(core_state)
    );

    // thread field: {valid, kind[1:0], target[2:0], irq, mon}
    // vector: {enh, th1[7:0], th0[7:0], exp0, exp1, expc}
    localparam int NV = 17;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 8'b0_00_000_0_0, 8'b1_00_000_0_0, 3'd1, 3'd0, 3'd0}, // R2 halt any target
        {1'b0, 8'b1_01_011_0_0, 8'b0_00_000_0_0, 3'd1, 3'd3, 3'd1}, // R3 mwait C3, R9
        {1'b0, 8'b1_10_100_0_0, 8'b0_00_000_0_1, 3'd1, 3'd3, 3'd1}, // R7 ignored, R8 dropped
        {1'b0, 8'b0_00_000_0_1, 8'b0_00_000_1_0, 3'd0, 3'd0, 3'd0}, // R7 mwait wake, R6
        {1'b0, 8'b1_10_100_0_0, 8'b1_10_100_0_0, 3'd4, 3'd4, 3'd4}, // R4 port C6, R9 both
        {1'b0, 8'b0_00_000_1_0, 8'b0_00_000_0_1, 3'd4, 3'd0, 3'd0}, // R7 port ignored, R6
        {1'b0, 8'b1_01_100_0_0, 8'b0_00_000_0_0, 3'd4, 3'd4, 3'd4}, // R3 mwait C6
        {1'b0, 8'b0_00_000_0_1, 8'b0_00_000_1_0, 3'd0, 3'd0, 3'd0}, // R6 R7
        {1'b1, 8'b1_00_101_0_0, 8'b1_01_001_0_0, 3'd2, 3'd2, 3'd2}, // R2 R3 enhanced
        {1'b0, 8'b0_00_000_0_0, 8'b0_00_000_1_0, 3'd0, 3'd2, 3'd0}, // R6 R5
        {1'b0, 8'b0_00_000_0_1, 8'b1_01_110_0_0, 3'd0, 3'd2, 3'd0}, // R3 bad target, R7
        {1'b0, 8'b0_00_000_1_0, 8'b1_10_001_0_0, 3'd0, 3'd0, 3'd0}, // R4 bad target, R6
        {1'b0, 8'b1_01_010_0_0, 8'b1_11_011_0_0, 3'd0, 3'd1, 3'd0}, // R8 reserved kind, R3
        {1'b0, 8'b0_00_000_0_0, 8'b1_01_011_0_0, 3'd3, 3'd1, 3'd1}, // R3 R9
        {1'b0, 8'b0_00_000_0_1, 8'b1_00_001_0_0, 3'd3, 3'd0, 3'd0}, // R8 busy drop, R7
        {1'b0, 8'b1_10_011_0_0, 8'b0_00_000_0_0, 3'd3, 3'd3, 3'd3}, // R4 port C3
        {1'b0, 8'b0_00_000_1_0, 8'b0_00_000_1_0, 3'd0, 3'd0, 3'd0}  // R6 both
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_thr(input int t, input logic [7:0] f);
        req_valid[t]            = f[7];
        req_kind[t*2 +: 2]      = f[6:5];
        req_target[t*3 +: 3]    = f[4:2];
        irq[t]                  = f[1];
        mon_hit[t]              = f[0];
    endtask

    task automatic idle_inputs();
        req_valid = '0; req_kind = '0; req_target = '0;
        irq = '0; mon_hit = '0; snoop_req = 1'b0;
    endtask

    // apply current inputs for one edge, then sample mid-cycle
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 thread0", int'(thread_state[2:0]), 0);
        check("R1 thread1", int'(thread_state[5:3]), 0);
        check("R1 core", int'(core_state), 0);
        check("R1 ack", int'(snoop_ack), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            enh_idle_en = VEC[i][25];
            drive_thr(1, VEC[i][24:17]);
            drive_thr(0, VEC[i][16:9]);
            step();
            check($sformatf("R2/R3/R4/R6/R7/R8 vec%0d thread0", i), int'(thread_state[2:0]), int'(VEC[i][8:6]));
            check($sformatf("R2/R3/R4/R6/R7/R8 vec%0d thread1", i), int'(thread_state[5:3]), int'(VEC[i][5:3]));
            check($sformatf("R9 vec%0d core", i), int'(core_state), int'(VEC[i][2:0]));
        end

        // R5: C1 then C1E entries, then toggle enable while idle
        @(negedge clk); idle_inputs(); enh_idle_en = 1'b0; drive_thr(0, 8'b1_00_000_0_0); step();
        @(negedge clk); idle_inputs(); enh_idle_en = 1'b1; drive_thr(1, 8'b1_00_000_0_0); step();
        check("R5 thread0 light", int'(thread_state[2:0]), 1);
        check("R5 thread1 enh", int'(thread_state[5:3]), 2);
        check("R9 mixed light core", int'(core_state), 1);
        @(negedge clk); idle_inputs(); enh_idle_en = 1'b0; step();
        @(negedge clk); enh_idle_en = 1'b1; step();
        check("R5 thread0 held", int'(thread_state[2:0]), 1);
        check("R5 thread1 held", int'(thread_state[5:3]), 2);

        // R10: snoop in light idle states, no wake
        @(negedge clk); enh_idle_en = 1'b0; snoop_req = 1'b1; step();
        check("R10 ack light", int'(snoop_ack), 1);
        check("R10 thread0 no wake", int'(thread_state[2:0]), 1);
        check("R10 thread1 no wake", int'(thread_state[5:3]), 2);
        @(negedge clk); snoop_req = 1'b0; step();
        check("R10 ack drops", int'(snoop_ack), 0);

        // R10: snoop while running
        @(negedge clk); irq = 2'b11; step();
        @(negedge clk); idle_inputs(); snoop_req = 1'b1; step();
        check("R10 ack run", int'(snoop_ack), 1);
        check("R10 core run", int'(core_state), 0);
        @(negedge clk); snoop_req = 1'b0; step();
        check("R10 ack run drops", int'(snoop_ack), 0);

        // R10: snoop in deepest state
        @(negedge clk); drive_thr(0, 8'b1_01_100_0_0); drive_thr(1, 8'b1_10_100_0_0); step();
        @(negedge clk); idle_inputs(); snoop_req = 1'b1; step();
        check("R10 ack deepest", int'(snoop_ack), 1);
        check("R10 core deepest kept", int'(core_state), 4);
        @(negedge clk); idle_inputs(); step();

        // R1: reset from idle states
        @(negedge clk); rst_n = 1'b0; step();
        check("R1 reset thread0", int'(thread_state[2:0]), 0);
        check("R1 reset core", int'(core_state), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule